// File: doc/BRIEF.md
# Bus-Mastering Block Transfer Engine with Cycle Stealing

This engine moves a block of words between one I/O device and memory over a shared bus, acting as bus master instead of the processor. Software first sets up a device address, a memory start address, a word count and a control word that picks the direction and the transfer mode. A start command then launches the transfer. The engine raises a bus request and waits for the owner of the bus to grant it. After that it performs the accesses itself. Each word takes a read from the source side into an internal holding register, then a write of that register to the destination side.

There are two modes. In block mode the request stays up until every word has moved. In cycle-steal mode the engine moves one word per grant. It then drops the request for a cycle so the owner can take the bus back, and asks again for the next word. When the count reaches zero the engine releases the bus and raises a level interrupt, which stays up until software clears it. A count of zero at start finishes at once, with no bus traffic.

Top module: `dma_steal_ctrl`

## Requirements
- R1: The configuration registers are selected by `cfg_addr` and read back through `cfg_rdata` combinationally. Offset 0 is control (write: bit 0 start, bit 1 direction, bit 2 steal mode, bit 3 clear done; read: bit 1 direction, bit 2 steal mode). Offset 1 is the device address, offset 2 the memory address, offset 3 the remaining count, and offset 4 status (bit 0 busy, bit 1 done).
- R2: `bus_valid` is asserted only while `bus_req` is high, and only after `bus_gnt` has been sampled high since `bus_req` last rose.
- R3: Each word is one read access (`bus_we`=0) of the source, then one write access (`bus_we`=1) to the destination carrying the data read. Direction 0 reads the device and writes memory. Direction 1 reads memory and writes the device. An access completes on a clock edge with `bus_valid` and `bus_ready` both high.
- R4: The memory address rises by one and the count falls by one for each word. The device address never changes. After a transfer, the memory register reads start+N and the count reads 0.
- R5: In block mode (steal bit 0), `bus_req` stays high between words, and the next word's read follows the previous write with no gap.
- R6: In steal mode, `bus_req` is low in the cycle after each word that is not the last, and the engine waits for a fresh grant before the next access.
- R7: In the cycle after the final write completes, `bus_req` is low, and `irq` and the done status bit are high.
- R8: `irq` stays high until a control write with bit 3 set. It is low from the cycle after that write.
- R9: If a done-clear write falls on the same edge as the completion of the final word, done stays set.
- R10: A start with a count of 0 sets done on that edge and raises no bus request.
- R11: While busy, writes to the control, device, memory and count registers are ignored, including a new start.
- R12: After reset, `bus_req`, `bus_valid` and `irq` are low, and every register reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | RW | Configuration write data |
| cfg_rdata | output | RW | Configuration read data for `cfg_addr` |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_valid | output | 1 | Master access strobe |
| bus_we | output | 1 | Access is a write |
| bus_addr | output | AW | Access address (device or memory) |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data |
| bus_ready | input | 1 | Access completes on this edge |
| irq | output | 1 | Completion interrupt, level |

## Verification
Two cases can land on the same clock edge, and the bench forces both. The first is software clearing done while the engine completes the last word, which sets done. The bench drives the clear write from the same negative-edge decision that grants the final write's `bus_ready`, so both take effect on one edge. The expected result is that `irq` is still high one cycle later. The second is a start command, or a register rewrite, that arrives while a steal-mode transfer is busy. Here the bench checks that the queue of expected accesses drains without one extra or altered access, and that the registers read back unchanged afterward.

// File: rtl/dma_steal_pkg.sv
`timescale 1ns/1ps
package dma_steal_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_GNT,
    ST_SRC,
    ST_DST,
    ST_GAP
  } seq_state_e;

  localparam int unsigned SEL_W = 3;

  localparam logic [SEL_W-1:0] OFS_CTRL = 3'd0;
  localparam logic [SEL_W-1:0] OFS_DEV  = 3'd1;
  localparam logic [SEL_W-1:0] OFS_MEM  = 3'd2;
  localparam logic [SEL_W-1:0] OFS_CNT  = 3'd3;
  localparam logic [SEL_W-1:0] OFS_STAT = 3'd4;

  localparam int unsigned CTL_GO    = 0;
  localparam int unsigned CTL_DIR   = 1;
  localparam int unsigned CTL_STEAL = 2;
  localparam int unsigned CTL_CLR   = 3;
  localparam int unsigned CTL_W     = 4;

endpackage

// File: rtl/dma_rst_sync.sv
`timescale 1ns/1ps
module dma_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/dma_regs.sv
`timescale 1ns/1ps
module dma_regs
  import dma_steal_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 16,
  parameter int unsigned RW = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [SEL_W-1:0]      cfg_addr,
  input  logic [CTL_W-1:0]      ctl_bits,
  input  logic [AW-1:0]         dev_wval,
  input  logic                  busy,
  input  logic                  finish,
  input  logic [AW-1:0]         mem_addr,
  input  logic [CW-1:0]         count,
  output logic [RW-1:0]         cfg_rdata,
  output logic                  go,
  output logic                  ld_mem,
  output logic                  ld_cnt,
  output logic                  dir,
  output logic                  steal,
  output logic [AW-1:0]         dev_addr,
  output logic                  done
);

  logic wr_ctrl, wr_dev;
  logic open_cfg;
  logic mode_en, dev_en, done_en;
  logic dir_d, steal_d, done_d;
  logic [AW-1:0] dev_d;
  logic dir_q, steal_q, done_q;
  logic [AW-1:0] dev_q;

  // write decode, gated by busy
  always_comb begin
    open_cfg = !busy;
    wr_ctrl  = cfg_we && (cfg_addr == OFS_CTRL);
    wr_dev   = cfg_we && (cfg_addr == OFS_DEV);
    ld_mem   = cfg_we && (cfg_addr == OFS_MEM) && open_cfg;
    ld_cnt   = cfg_we && (cfg_addr == OFS_CNT) && open_cfg;
    go       = wr_ctrl && ctl_bits[CTL_GO] && open_cfg;
  end

  // next-state
  always_comb begin
    mode_en = wr_ctrl && open_cfg;
    dir_d   = ctl_bits[CTL_DIR];
    steal_d = ctl_bits[CTL_STEAL];
    dev_en  = wr_dev && open_cfg;
    dev_d   = dev_wval;
    done_en = finish || (wr_ctrl && ctl_bits[CTL_CLR]);
    // completion outranks a simultaneous clear
    done_d  = finish;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= 1'b0;
      steal_q <= 1'b0;
    end else if (mode_en) begin
      dir_q   <= dir_d;
      steal_q <= steal_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dev_q <= '0;
    end else if (dev_en) begin
      dev_q <= dev_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else if (done_en) begin
      done_q <= done_d;
    end
  end

  // read mux
  always_comb begin
    cfg_rdata = '0;
    unique case (cfg_addr)
      OFS_CTRL: begin
        cfg_rdata[CTL_DIR]   = dir_q;
        cfg_rdata[CTL_STEAL] = steal_q;
      end
      OFS_DEV:  cfg_rdata[AW-1:0] = dev_q;
      OFS_MEM:  cfg_rdata[AW-1:0] = mem_addr;
      OFS_CNT:  cfg_rdata[CW-1:0] = count;
      OFS_STAT: begin
        cfg_rdata[0] = busy;
        cfg_rdata[1] = done_q;
      end
      default:  cfg_rdata = '0;
    endcase
  end

  assign dir      = dir_q;
  assign steal    = steal_q;
  assign dev_addr = dev_q;
  assign done     = done_q;

endmodule

// File: rtl/dma_datapath.sv
`timescale 1ns/1ps
module dma_datapath #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16,
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_mem,
  input  logic          ld_cnt,
  input  logic [AW-1:0] mem_wval,
  input  logic [CW-1:0] cnt_wval,
  input  logic          capture,
  input  logic          word_done,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] mem_addr,
  output logic [CW-1:0] count,
  output logic [DW-1:0] hold,
  output logic          cnt_zero,
  output logic          cnt_last
);

  localparam logic [AW-1:0] ADDR_STEP = AW'(1);
  localparam logic [CW-1:0] CNT_ONE   = CW'(1);

  logic          mem_en, cnt_en;
  logic [AW-1:0] mem_d, mem_q;
  logic [CW-1:0] cnt_d, cnt_q;
  logic [DW-1:0] hold_q;

  always_comb begin
    mem_en = ld_mem || word_done;
    mem_d  = ld_mem ? mem_wval : (mem_q + ADDR_STEP);
    cnt_en = ld_cnt || word_done;
    cnt_d  = ld_cnt ? cnt_wval : (cnt_q - CNT_ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
    end else if (mem_en) begin
      mem_q <= mem_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (capture) begin
      hold_q <= rd_data;
    end
  end

  assign mem_addr = mem_q;
  assign count    = cnt_q;
  assign hold     = hold_q;
  assign cnt_zero = (cnt_q == '0);
  assign cnt_last = (cnt_q == CNT_ONE);

endmodule

// File: rtl/dma_seq.sv
`timescale 1ns/1ps
module dma_seq
  import dma_steal_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic steal,
  input  logic cnt_zero,
  input  logic cnt_last,
  input  logic bus_gnt,
  input  logic bus_ready,
  output logic bus_req,
  output logic acc_src,
  output logic acc_dst,
  output logic capture,
  output logic word_done,
  output logic finish,
  output logic busy
);

  seq_state_e state_q, state_d;

  always_comb begin
    state_d   = state_q;
    capture   = 1'b0;
    word_done = 1'b0;
    finish    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (go) begin
          if (cnt_zero) begin
            finish = 1'b1;
          end else begin
            state_d = ST_WAIT_GNT;
          end
        end
      end
      ST_WAIT_GNT: begin
        if (bus_gnt) begin
          state_d = ST_SRC;
        end
      end
      ST_SRC: begin
        if (bus_ready) begin
          capture = 1'b1;
          state_d = ST_DST;
        end
      end
      ST_DST: begin
        if (bus_ready) begin
          word_done = 1'b1;
          if (cnt_last) begin
            finish  = 1'b1;
            state_d = ST_IDLE;
          end else if (steal) begin
            state_d = ST_GAP;
          end else begin
            state_d = ST_SRC;
          end
        end
      end
      ST_GAP: begin
        state_d = ST_WAIT_GNT;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign bus_req = (state_q == ST_WAIT_GNT) || (state_q == ST_SRC) || (state_q == ST_DST);
  assign acc_src = (state_q == ST_SRC);
  assign acc_dst = (state_q == ST_DST);
  assign busy    = (state_q != ST_IDLE);

endmodule

// File: rtl/dma_steal_ctrl.sv
`timescale 1ns/1ps
module dma_steal_ctrl
  import dma_steal_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 16,
  parameter int unsigned CW = 16,
  parameter int unsigned RW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_addr,
  input  logic [RW-1:0]    cfg_wdata,
  output logic [RW-1:0]    cfg_rdata,
  output logic             bus_req,
  input  logic             bus_gnt,
  output logic             bus_valid,
  output logic             bus_we,
  output logic [AW-1:0]    bus_addr,
  output logic [DW-1:0]    bus_wdata,
  input  logic [DW-1:0]    bus_rdata,
  input  logic             bus_ready,
  output logic             irq
);

  logic          rst_n_int;
  logic          go, ld_mem, ld_cnt, dir, steal, done;
  logic [AW-1:0] dev_addr, mem_addr;
  logic [CW-1:0] count;
  logic [DW-1:0] hold;
  logic          cnt_zero, cnt_last;
  logic          acc_src, acc_dst, capture, word_done, finish, busy;
  logic          mem_side;
  logic          unused_wdata;

  assign unused_wdata = ^cfg_wdata;

  dma_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  dma_regs #(.AW(AW), .CW(CW), .RW(RW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .ctl_bits  (cfg_wdata[CTL_W-1:0]),
    .dev_wval  (cfg_wdata[AW-1:0]),
    .busy      (busy),
    .finish    (finish),
    .mem_addr  (mem_addr),
    .count     (count),
    .cfg_rdata (cfg_rdata),
    .go        (go),
    .ld_mem    (ld_mem),
    .ld_cnt    (ld_cnt),
    .dir       (dir),
    .steal     (steal),
    .dev_addr  (dev_addr),
    .done      (done)
  );

  dma_datapath #(.AW(AW), .DW(DW), .CW(CW)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .ld_mem    (ld_mem),
    .ld_cnt    (ld_cnt),
    .mem_wval  (cfg_wdata[AW-1:0]),
    .cnt_wval  (cfg_wdata[CW-1:0]),
    .capture   (capture),
    .word_done (word_done),
    .rd_data   (bus_rdata),
    .mem_addr  (mem_addr),
    .count     (count),
    .hold      (hold),
    .cnt_zero  (cnt_zero),
    .cnt_last  (cnt_last)
  );

  dma_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .go        (go),
    .steal     (steal),
    .cnt_zero  (cnt_zero),
    .cnt_last  (cnt_last),
    .bus_gnt   (bus_gnt),
    .bus_ready (bus_ready),
    .bus_req   (bus_req),
    .acc_src   (acc_src),
    .acc_dst   (acc_dst),
    .capture   (capture),
    .word_done (word_done),
    .finish    (finish),
    .busy      (busy)
  );

  // direction 1: memory is the source; direction 0: memory is the destination
  always_comb begin
    mem_side  = acc_src ? dir : !dir;
    bus_valid = acc_src || acc_dst;
    bus_we    = acc_dst;
    bus_addr  = mem_side ? mem_addr : dev_addr;
    bus_wdata = hold;
    irq       = done;
  end

endmodule

// File: rtl/dma_steal_chk.sv
`timescale 1ns/1ps
module dma_steal_chk #(
  parameter int unsigned AW = 16,
  parameter int unsigned RW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [2:0]    cfg_addr,
  input logic [RW-1:0] cfg_wdata,
  input logic          bus_req,
  input logic          bus_valid,
  input logic          bus_we,
  input logic          bus_ready,
  input logic [AW-1:0] bus_addr,
  input logic          irq
);

  a_r2_valid_under_req: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> bus_req);

  a_r2_no_access_on_request: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> !bus_valid);

  a_r3_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_we && !$past(bus_valid && bus_we)) |-> $past(bus_valid && !bus_we && bus_ready));

  a_r3_access_held: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=> (bus_valid && $stable(bus_addr) && $stable(bus_we)));

  a_r7_release_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq) && $past(bus_req)) |-> !bus_req);

  a_r8_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(cfg_we && cfg_addr == 3'd0 && cfg_wdata[3])) |=> irq);

endmodule

bind dma_steal_ctrl dma_steal_chk #(.AW(AW), .RW(RW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_we    (cfg_we),
  .cfg_addr  (cfg_addr),
  .cfg_wdata (cfg_wdata),
  .bus_req   (bus_req),
  .bus_valid (bus_valid),
  .bus_we    (bus_we),
  .bus_ready (bus_ready),
  .bus_addr  (bus_addr),
  .irq       (irq)
);

// File: tb/dma_steal_ctrl_tb_top.sv
`timescale 1ns/1ps
module dma_steal_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_addr;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        bus_req, bus_gnt, bus_valid, bus_we, bus_ready;
  logic [15:0] bus_addr, bus_wdata, bus_rdata;
  logic        irq;

  always #2.5 clk = ~clk;

  dma_steal_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .bus_valid(bus_valid), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  int tick = 0;
  int devcnt = 0;
  int gnt_wait = 0;
  bit granted = 0;
  bit exp_fin = 0, exp_gap = 0, exp_hold = 0;
  bit steal_cur = 0;
  bit collide_arm = 0, collide_fire = 0;
  logic [15:0] memm [0:255];
  logic [15:0] q_addr[$];
  bit          q_we[$];
  logic [15:0] q_data[$];

  function automatic logic [15:0] dev_val(int k);
    return 16'hD000 + k[15:0];
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one cycle of the reference model and bus responder, at the falling edge
  task automatic step();
    bit last_word;
    @(negedge clk);
    tick++;
    if (exp_fin) begin
      chk(irq == 1'b1, "R7", "irq after last word", irq, 1);
      chk(bus_req == 1'b0, "R7", "bus_req after last word", bus_req, 0);
      exp_fin = 0;
    end
    if (exp_gap) begin
      chk(bus_req == 1'b0, "R6", "bus_req gap after word", bus_req, 0);
      exp_gap = 0;
    end
    if (exp_hold) begin
      chk(bus_req && bus_valid, "R5", "bus held into next word", {bus_req, bus_valid}, 3);
      exp_hold = 0;
    end
    if (collide_fire) begin
      cfg_we = 1'b0;
      collide_fire = 0;
    end
    if (bus_valid) chk(granted, "R2", "access without grant", 0, 1);
    if (!bus_req) begin
      granted = 0; gnt_wait = 0; bus_gnt = 1'b0;
    end else if (!granted) begin
      gnt_wait++;
      if (gnt_wait >= 3) begin
        bus_gnt = 1'b1; granted = 1;
      end
    end
    bus_ready = bus_valid && ((tick % 3) != 0);
    bus_rdata = (bus_addr[15:12] == 4'hF) ? dev_val(devcnt) : memm[bus_addr[7:0]];
    if (bus_valid && bus_ready) begin
      if (q_addr.size() == 0) begin
        chk(0, "R11", "unexpected bus access", bus_addr, 0);
      end else begin
        chk(bus_addr == q_addr[0], "R3", "access address", bus_addr, q_addr[0]);
        chk(bus_we == q_we[0], "R3", "access kind", bus_we, q_we[0]);
        if (q_we[0]) chk(bus_wdata == q_data[0], "R3", "write data", bus_wdata, q_data[0]);
        void'(q_addr.pop_front()); void'(q_data.pop_front());
        last_word = (q_addr.size() == 0);
        if (!q_we.pop_front() && bus_addr[15:12] == 4'hF) devcnt++;
        if (bus_we && bus_addr[15:12] != 4'hF) memm[bus_addr[7:0]] = bus_wdata;
        if (last_word) begin
          exp_fin = 1;
          if (collide_arm) begin
            cfg_we = 1'b1; cfg_addr = 3'd0; cfg_wdata = 32'h8;
            collide_arm = 0; collide_fire = 1;
          end
        end else if (bus_we) begin
          if (steal_cur) exp_gap = 1; else exp_hold = 1;
        end
      end
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    cfg_addr = a;
    #0.1;
    d = cfg_rdata;
  endtask

  task automatic run_xfer(bit dir, bit steal, logic [15:0] dev, logic [15:0] mem,
                          int n, bit collide, bit poke);
    for (int k = 0; k < n; k++) begin
      if (!dir) begin
        q_addr.push_back(dev);         q_we.push_back(0); q_data.push_back(16'h0);
        q_addr.push_back(mem + 16'(k)); q_we.push_back(1); q_data.push_back(dev_val(devcnt + k));
      end else begin
        q_addr.push_back(mem + 16'(k)); q_we.push_back(0); q_data.push_back(16'h0);
        q_addr.push_back(dev);         q_we.push_back(1); q_data.push_back(memm[8'(mem + 16'(k))]);
      end
    end
    steal_cur = steal;
    wr(3'd1, {16'h0, dev});
    wr(3'd2, {16'h0, mem});
    wr(3'd3, 32'(n));
    collide_arm = collide;
    wr(3'd0, {29'h0, steal, dir, 1'b1});
    for (int i = 0; i < 3000 && (q_addr.size() != 0 || exp_fin); i++) begin
      if (poke) begin
        if (i == 3) begin cfg_we = 1; cfg_addr = 3'd0; cfg_wdata = {29'h0, !steal, !dir, 1'b1}; end
        if (i == 4) begin cfg_we = 1; cfg_addr = 3'd3; cfg_wdata = 32'h55; end
        if (i == 5) begin cfg_we = 1; cfg_addr = 3'd2; cfg_wdata = 32'h80; end
        if (i == 6) begin cfg_we = 1; cfg_addr = 3'd1; cfg_wdata = 32'hF0EE; end
        if (i == 7) cfg_we = 0;
      end
      step();
    end
    cfg_we = 1'b0;
    chk(q_addr.size() == 0, "R3", "all expected accesses done", q_addr.size(), 0);
  endtask

  logic [31:0] rv;

  initial begin
    for (int i = 0; i < 256; i++) memm[i] = 16'h3000 + 16'(i * 5);
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = 3'd0; cfg_wdata = '0;
    bus_gnt = 1'b0; bus_ready = 1'b0; bus_rdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step();

    // R12 reset state
    chk(!bus_req && !bus_valid && !irq, "R12", "outputs after reset", {bus_req, bus_valid, irq}, 0);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), rv);
      chk(rv == 0, "R12", "register after reset", rv, 0);
    end

    // R1 readback
    wr(3'd1, 32'hF00A); wr(3'd2, 32'h40); wr(3'd3, 32'h5); wr(3'd0, 32'h6);
    rd(3'd0, rv); chk(rv == 32'h6, "R1", "control readback", rv, 6);
    rd(3'd1, rv); chk(rv == 32'hF00A, "R1", "device readback", rv, 32'hF00A);
    rd(3'd2, rv); chk(rv == 32'h40, "R1", "memory readback", rv, 32'h40);
    rd(3'd3, rv); chk(rv == 32'h5, "R1", "count readback", rv, 5);
    rd(3'd4, rv); chk(rv == 32'h0, "R1", "status idle", rv, 0);

    // block mode, device to memory
    run_xfer(0, 0, 16'hF00A, 16'h10, 4, 0, 0);
    rd(3'd2, rv); chk(rv == 32'h14, "R4", "memory address after block", rv, 32'h14);
    rd(3'd3, rv); chk(rv == 32'h0, "R4", "count after block", rv, 0);
    rd(3'd1, rv); chk(rv == 32'hF00A, "R4", "device address kept", rv, 32'hF00A);
    rd(3'd4, rv); chk(rv == 32'h2, "R7", "status done not busy", rv, 2);
    for (int i = 0; i < 4; i++) begin
      step();
      chk(irq == 1'b1, "R8", "irq held", irq, 1);
    end
    wr(3'd0, 32'h8);
    chk(irq == 1'b0, "R8", "irq after clear", irq, 0);
    rd(3'd4, rv); chk(rv == 32'h0, "R8", "status after clear", rv, 0);

    // steal mode, memory to device
    run_xfer(1, 1, 16'hF003, 16'h20, 3, 0, 0);
    rd(3'd2, rv); chk(rv == 32'h23, "R4", "memory address after steal", rv, 32'h23);
    rd(3'd3, rv); chk(rv == 32'h0, "R4", "count after steal", rv, 0);

    // done still set: clear collides with final word
    run_xfer(0, 0, 16'hF011, 16'h30, 2, 1, 0);
    repeat (2) step();
    rd(3'd4, rv); chk(rv[1] == 1'b1, "R9", "done survives same-edge clear", rv[1], 1);
    wr(3'd0, 32'h8);

    // writes while busy are ignored
    run_xfer(0, 1, 16'hF020, 16'h50, 5, 0, 1);
    repeat (6) step();
    rd(3'd3, rv); chk(rv == 32'h0, "R11", "count not rewritten", rv, 0);
    rd(3'd2, rv); chk(rv == 32'h55, "R11", "memory address not rewritten", rv, 32'h55);
    rd(3'd1, rv); chk(rv == 32'hF020, "R11", "device address not rewritten", rv, 32'hF020);
    rd(3'd0, rv); chk(rv == 32'h4, "R11", "mode not rewritten", rv, 4);
    wr(3'd0, 32'h8);

    // zero count
    wr(3'd3, 32'h0);
    wr(3'd0, 32'h1);
    chk(irq == 1'b1, "R10", "done at once on zero count", irq, 1);
    for (int i = 0; i < 5; i++) begin
      chk(bus_req == 1'b0, "R10", "no request on zero count", bus_req, 0);
      step();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
    $finish;
  end

endmodule